// File: doc/BRIEF.md
# USB Device IN Endpoint Controller

This block holds the control and status state of a single USB device IN endpoint. A CPU writes and reads one packed control/status byte, and a packet engine delivers single-cycle strobes for an IN token, a start-of-frame marker, a host handshake ACK and the end of a packet transmission. For every IN token the block picks the answer the engine must send. The answer is a DATA0 or DATA1 data packet, a NAK, a STALL handshake or a zero-length packet. The choice depends on the stall request, the number of packets waiting and the transfer mode.

The endpoint runs in one of two modes, bulk/interrupt or isochronous. It can hold one packet slot, or two when double buffering is on. In isochronous mode an option makes each newly committed packet wait for the next start-of-frame before it can be sent. The block keeps the data toggle and discards packets on request. It raises sticky flags for sent stalls and underruns, and it pulses an interrupt when a data packet finishes transmitting.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After synchronous reset the control byte reads 0x00, and neither a response strobe nor an interrupt is active.
- R2: Bit 7 of the control byte is always read as 0 and writes to it do nothing. Writing 1 to bit 6 forces the toggle to DATA0, so the next bulk data response is DATA0. Bit 6 is always read as 0.
- R3: Bit 4 holds the stall request. While it is 1 in bulk/interrupt mode, an IN token is answered with STALL. The same token sets the sent-stall flag (bit 5) and empties every packet slot, so bits 1 and 0 read 0. In isochronous mode bit 4 has no effect.
- R4: The sent-stall flag (bit 5) and the underrun flag (bit 2) are cleared only by writing 0 to their own bit. Writing 1 to either bit leaves it unchanged. If a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.
- R5: Writing 1 to bit 3 makes bit 3 read 1 for one cycle. In the following cycle exactly one waiting packet is discarded and bit 3 reads 0 again.
- R6: An IN token that arrives with no packet waiting sets the underrun flag. In bulk/interrupt mode it is answered with NAK, and in isochronous mode with a zero-length packet.
- R7: Bit 1 reads 1 whenever at least one packet (including one that is waiting for start-of-frame) is held, and 0 otherwise.
- R8: Writing 1 to bit 0 commits a packet if a slot is free. Bit 0 then reads 1 only while every slot is full: with one slot, from the commit until the transmission completes; with two slots, only when both hold packets. A commit and a transmission completion in the same cycle leave the packet count unchanged.
- R9: In isochronous mode with update-on-start-of-frame enabled, a committed packet keeps bit 0 at 0 and cannot be sent until the next start-of-frame strobe. Until then, IN tokens get a zero-length packet.
- R10: When the interrupt enable is high, the interrupt output pulses for one cycle, one cycle after the transmission-done strobe that ends a sent data packet. A flush, a stall or a disabled enable gives no pulse.
- R11: In bulk/interrupt mode a data response carries the current toggle, and the toggle flips on the host ACK that follows it. In isochronous mode data always goes out as DATA0 and the toggle is not changed.
- R12: The response strobe is high for exactly one cycle, the cycle after each IN token. The response kind codes are DATA0=0, DATA1=1, NAK=2, STALL=3 and zero-length=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_iso | input | 1 | 1 selects isochronous mode, 0 selects bulk/interrupt |
| cfg_dbl | input | 1 | Double buffering: two packet slots instead of one |
| cfg_sof_upd | input | 1 | Isochronous packets become sendable only at start-of-frame |
| irq_en | input | 1 | Interrupt enable |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data for the control byte |
| reg_rdata | output | 8 | Current control/status byte |
| tok_in | input | 1 | IN token strobe from the packet engine |
| sof | input | 1 | Start-of-frame strobe |
| host_ack | input | 1 | Host ACK handshake strobe |
| tx_done | input | 1 | Data packet transmission complete strobe |
| resp_valid | output | 1 | Response decision strobe |
| resp_kind | output | 3 | Response kind, coded as in R12 |
| irq | output | 1 | Transmit-complete interrupt pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a hardware set of the underrun flag and a software write that clears it. The bench drives an IN token on an empty endpoint together with a write of 0x00. It then expects the underrun bit to read 1 and the response to be NAK. The second pair is a packet commit and a transmission completion in one cycle. Here the bench expects the slot count to stay unchanged, which it judges from the readback bits, the interrupt pulse and a data response to the next token.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    typedef enum logic [2:0] {
        RSP_DATA0 = 3'd0,
        RSP_DATA1 = 3'd1,
        RSP_NAK   = 3'd2,
        RSP_STALL = 3'd3,
        RSP_ZLP   = 3'd4
    } rsp_kind_e;

    localparam int BIT_CLRTOG  = 6;
    localparam int BIT_SENTSTL = 5;
    localparam int BIT_STALL   = 4;
    localparam int BIT_FLUSH   = 3;
    localparam int BIT_URUN    = 2;
    localparam int BIT_NE      = 1;
    localparam int BIT_RDY     = 0;

    localparam int FLAG_SENTSTL = 0;
    localparam int FLAG_URUN    = 1;
    localparam int NUM_FLAGS    = 2;

    typedef struct packed {
        logic clr_tog;
        logic sentstl_clr;
        logic stall_wr;
        logic stall_val;
        logic flush;
        logic urun_clr;
        logic commit;
    } wr_cmd_t;

    typedef struct packed {
        rsp_kind_e kind;
        logic      stall_evt;
        logic      urun_evt;
        logic      launch;
        logic      launch_bulk;
    } decision_t;

    function automatic wr_cmd_t decode_wr(input logic wr, input logic [7:0] d);
        wr_cmd_t c;
        c.clr_tog     = wr & d[BIT_CLRTOG];
        c.sentstl_clr = wr & ~d[BIT_SENTSTL];
        c.stall_wr    = wr;
        c.stall_val   = d[BIT_STALL];
        c.flush       = wr & d[BIT_FLUSH];
        c.urun_clr    = wr & ~d[BIT_URUN];
        c.commit      = wr & d[BIT_RDY];
        return c;
    endfunction

endpackage

// File: rtl/usb_in_ep_sticky.sv
module usb_in_ep_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)            flag_q <= 1'b0;
            else if (hw_set[i]) flag_q <= 1'b1;
            else if (sw_clr[i]) flag_q <= 1'b0;
        end
        assign q[i] = flag_q;
    end
endmodule

// File: rtl/usb_in_ep_toggle.sv
module usb_in_ep_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic launch_bulk,
    input  logic host_ack,
    output logic tog
);
    logic tog_q;
    logic ack_wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q      <= 1'b0;
            ack_wait_q <= 1'b0;
        end else begin
            if (clr)                          tog_q <= 1'b0;
            else if (host_ack && ack_wait_q)  tog_q <= ~tog_q;
            if (launch_bulk)                  ack_wait_q <= 1'b1;
            else if (host_ack)                ack_wait_q <= 1'b0;
        end
    end

    assign tog = tog_q;

    p_clear_forces_data0_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> !tog);

    p_ack_flips_r11: assert property (@(posedge clk) disable iff (rst)
        host_ack && ack_wait_q && !clr |=> tog != $past(tog));

endmodule

// File: rtl/usb_in_ep_slots.sv
module usb_in_ep_slots #(
    parameter int DBL_SLOTS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_dbl,
    input  logic stage_mode,
    input  logic commit,
    input  logic flush_req,
    input  logic sof,
    input  logic wipe,
    input  logic launch,
    input  logic tx_done,
    output logic pend_nz,
    output logic rdy_rd,
    output logic fifo_ne,
    output logic flush_busy,
    output logic tx_fin
);
    localparam int CNT_W = $clog2(DBL_SLOTS + 1);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] pend_q, pend_n, cap;
    logic             staged_q, staged_n;
    logic             busy_q, flush_q;
    logic [EXT_W-1:0] pend_x, occ, cap_x, dec_raw, dec_total;
    logic             inc_direct, stage_set, promote, dec_tx, dec_fl, drop_staged;

    always_comb begin
        cap         = cfg_dbl ? CNT_W'(DBL_SLOTS) : CNT_W'(1);
        cap_x       = {1'b0, cap};
        pend_x      = {1'b0, pend_q};
        occ         = pend_x + EXT_W'(staged_q);
        tx_fin      = tx_done & busy_q;
        inc_direct  = commit & ~stage_mode & (occ < cap_x);
        stage_set   = commit & stage_mode & ~staged_q & (occ < cap_x);
        dec_tx      = tx_fin & (pend_q != '0);
        dec_fl      = flush_q & (pend_q != '0);
        drop_staged = flush_q & (pend_q == '0) & staged_q;
        promote     = sof & staged_q & ~drop_staged;
        dec_raw     = EXT_W'(dec_tx) + EXT_W'(dec_fl);
        dec_total   = (dec_raw > pend_x) ? pend_x : dec_raw;

        if (wipe) begin
            pend_n   = '0;
            staged_n = 1'b0;
        end else begin
            pend_n = CNT_W'(pend_x + EXT_W'(inc_direct) + EXT_W'(promote) - dec_total);
            if (stage_set)                   staged_n = 1'b1;
            else if (promote || drop_staged) staged_n = 1'b0;
            else                             staged_n = staged_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            staged_q <= 1'b0;
            busy_q   <= 1'b0;
            flush_q  <= 1'b0;
        end else begin
            pend_q   <= pend_n;
            staged_q <= staged_n;
            busy_q   <= launch | (busy_q & ~tx_done);
            flush_q  <= flush_req;
        end
    end

    assign pend_nz    = (pend_q != '0);
    assign rdy_rd     = ~staged_q & (pend_q == cap);
    assign fifo_ne    = (occ != '0);
    assign flush_busy = flush_q;

    p_ne_covers_rdy_r7: assert property (@(posedge clk) disable iff (rst)
        rdy_rd |-> fifo_ne);

    p_sof_promotes_r9: assert property (@(posedge clk) disable iff (rst)
        sof && staged_q && !flush_q && !wipe |=> !staged_q && pend_q != '0);

    p_flush_drops_one_r5: assert property (@(posedge clk) disable iff (rst)
        flush_q && pend_q != '0 && !tx_fin && !inc_direct && !promote && !wipe
        |=> pend_q == $past(pend_q) - 1'b1);

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int DBL_SLOTS = 2,
    parameter int REG_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_iso,
    input  logic             cfg_dbl,
    input  logic             cfg_sof_upd,
    input  logic             irq_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tok_in,
    input  logic             sof,
    input  logic             host_ack,
    input  logic             tx_done,
    output logic             resp_valid,
    output logic [2:0]       resp_kind,
    output logic             irq
);
    wr_cmd_t        cmd;
    decision_t      dec;
    logic           stall_q;
    logic           tog;
    logic           pend_nz, rdy_rd, fifo_ne, flush_busy, tx_fin;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;
    logic           resp_valid_q, irq_q;
    rsp_kind_e      resp_kind_q;

    assign cmd = decode_wr(reg_wr, reg_wdata[7:0]);

    always_comb begin
        dec = '{kind: RSP_NAK, stall_evt: 1'b0, urun_evt: 1'b0,
                launch: 1'b0, launch_bulk: 1'b0};
        if (tok_in) begin
            if (stall_q && !cfg_iso) begin
                dec.kind      = RSP_STALL;
                dec.stall_evt = 1'b1;
            end else if (!pend_nz) begin
                dec.kind     = cfg_iso ? RSP_ZLP : RSP_NAK;
                dec.urun_evt = 1'b1;
            end else begin
                dec.kind        = (cfg_iso || !tog) ? RSP_DATA0 : RSP_DATA1;
                dec.launch      = 1'b1;
                dec.launch_bulk = ~cfg_iso;
            end
        end
    end

    usb_in_ep_slots #(.DBL_SLOTS(DBL_SLOTS)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .cfg_dbl    (cfg_dbl),
        .stage_mode (cfg_iso & cfg_sof_upd),
        .commit     (cmd.commit),
        .flush_req  (cmd.flush),
        .sof        (sof),
        .wipe       (dec.stall_evt),
        .launch     (dec.launch),
        .tx_done    (tx_done),
        .pend_nz    (pend_nz),
        .rdy_rd     (rdy_rd),
        .fifo_ne    (fifo_ne),
        .flush_busy (flush_busy),
        .tx_fin     (tx_fin)
    );

    usb_in_ep_toggle u_toggle (
        .clk         (clk),
        .rst         (rst),
        .clr         (cmd.clr_tog),
        .launch_bulk (dec.launch_bulk),
        .host_ack    (host_ack),
        .tog         (tog)
    );

    always_comb begin
        flag_set[FLAG_SENTSTL] = dec.stall_evt;
        flag_clr[FLAG_SENTSTL] = cmd.sentstl_clr;
        flag_set[FLAG_URUN]    = dec.urun_evt;
        flag_clr[FLAG_URUN]    = cmd.urun_clr;
    end

    usb_in_ep_sticky #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .hw_set (flag_set),
        .sw_clr (flag_clr),
        .q      (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q      <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_kind_q  <= RSP_DATA0;
            irq_q        <= 1'b0;
        end else begin
            if (cmd.stall_wr) stall_q <= cmd.stall_val;
            resp_valid_q <= tok_in;
            if (tok_in) resp_kind_q <= dec.kind;
            irq_q        <= irq_en & tx_fin;
        end
    end

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[BIT_SENTSTL] = flags[FLAG_SENTSTL];
        reg_rdata[BIT_STALL]   = stall_q;
        reg_rdata[BIT_FLUSH]   = flush_busy;
        reg_rdata[BIT_URUN]    = flags[FLAG_URUN];
        reg_rdata[BIT_NE]      = fifo_ne;
        reg_rdata[BIT_RDY]     = rdy_rd;
    end

    assign resp_valid = resp_valid_q;
    assign resp_kind  = resp_kind_q;
    assign irq        = irq_q;

    p_resp_after_token_r12: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(tok_in));

    p_stall_marks_and_empties_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_kind == RSP_STALL |-> reg_rdata[BIT_SENTSTL] && !reg_rdata[BIT_NE]);

    p_underrun_flag_r6: assert property (@(posedge clk) disable iff (rst)
        resp_valid && (resp_kind == RSP_NAK || resp_kind == RSP_ZLP) |-> reg_rdata[BIT_URUN]);

    p_hw_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        tok_in && !pend_nz && !(stall_q && !cfg_iso) && reg_wr |=> reg_rdata[BIT_URUN]);

    p_iso_only_data0_r11: assert property (@(posedge clk) disable iff (rst)
        resp_valid && $past(cfg_iso) |-> resp_kind != RSP_DATA1 && resp_kind != RSP_STALL);

    p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tx_done) && $past(irq_en));

endmodule

// File: tb/usb_in_ep_ctrl_bench.sv
module usb_in_ep_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_iso, cfg_dbl, cfg_sof_upd, irq_en;
    logic       reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       tok_in, sof, host_ack, tx_done;
    logic       resp_valid, irq;
    logic [2:0] resp_kind;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    usb_in_ep_ctrl u_usb_in_ep_ctrl (
        .clk(clk), .rst(rst), .cfg_iso(cfg_iso), .cfg_dbl(cfg_dbl),
        .cfg_sof_upd(cfg_sof_upd), .irq_en(irq_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_in(tok_in),
        .sof(sof), .host_ack(host_ack), .tx_done(tx_done),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .irq(irq)
    );

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_WR  = 3'd1;
    localparam logic [2:0] OP_TOK = 3'd2;
    localparam logic [2:0] OP_SOF = 3'd3;
    localparam logic [2:0] OP_TXD = 3'd4;
    localparam logic [2:0] OP_ACK = 3'd5;
    localparam logic [3:0] NONE   = 4'hF;

    // cfg = {irq_en, sof_upd, dbl, iso}; rsp NONE = no response strobe expected
    typedef struct packed {
        logic [3:0] cfg;
        logic [2:0] op;
        logic [7:0] wd;
        logic [7:0] rd;
        logic [3:0] rsp;
        logic       irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t VEC [NV] = '{
        '{4'h8, OP_NOP, 8'h00, 8'h00, NONE, 1'b0, 4'd1},   // R1
        '{4'h8, OP_TOK, 8'h00, 8'h04, 4'h2, 1'b0, 4'd6},   // R6 NAK
        '{4'h8, OP_WR,  8'h04, 8'h04, NONE, 1'b0, 4'd4},   // R4 write 1 keeps
        '{4'h8, OP_WR,  8'h00, 8'h00, NONE, 1'b0, 4'd4},   // R4 write 0 clears
        '{4'h8, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},   // R8 R7
        '{4'h8, OP_TOK, 8'h00, 8'h03, 4'h0, 1'b0, 4'd11},  // R11 DATA0
        '{4'h8, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd10},  // R10
        '{4'h8, OP_ACK, 8'h00, 8'h00, NONE, 1'b0, 4'd12},  // R12
        '{4'h8, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},
        '{4'h8, OP_TOK, 8'h00, 8'h03, 4'h1, 1'b0, 4'd11},  // R11 DATA1
        '{4'h8, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd10},
        '{4'h8, OP_ACK, 8'h00, 8'h00, NONE, 1'b0, 4'd11},
        '{4'h8, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},
        '{4'h8, OP_TOK, 8'h00, 8'h03, 4'h0, 1'b0, 4'd11},
        '{4'h8, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd10},
        '{4'h8, OP_ACK, 8'h00, 8'h00, NONE, 1'b0, 4'd11},
        '{4'h8, OP_WR,  8'h41, 8'h03, NONE, 1'b0, 4'd2},   // R2 clear toggle
        '{4'h8, OP_TOK, 8'h00, 8'h03, 4'h0, 1'b0, 4'd2},   // R2 DATA0
        '{4'h8, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd10},
        '{4'h8, OP_ACK, 8'h00, 8'h00, NONE, 1'b0, 4'd11},
        '{4'h8, OP_WR,  8'h11, 8'h13, NONE, 1'b0, 4'd3},
        '{4'h8, OP_TOK, 8'h00, 8'h30, 4'h3, 1'b0, 4'd3},   // R3 STALL
        '{4'h8, OP_WR,  8'h20, 8'h20, NONE, 1'b0, 4'd4},   // R4
        '{4'h8, OP_WR,  8'h00, 8'h00, NONE, 1'b0, 4'd4},
        '{4'h8, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},
        '{4'h8, OP_WR,  8'h08, 8'h0B, NONE, 1'b0, 4'd5},   // R5
        '{4'h8, OP_NOP, 8'h00, 8'h00, NONE, 1'b0, 4'd5},   // R5
        '{4'h8, OP_TOK, 8'h00, 8'h04, 4'h2, 1'b0, 4'd6},
        '{4'h8, OP_WR,  8'h80, 8'h00, NONE, 1'b0, 4'd2},   // R2 bit 7
        '{4'h9, OP_WR,  8'h10, 8'h10, NONE, 1'b0, 4'd3},
        '{4'h9, OP_WR,  8'h11, 8'h13, NONE, 1'b0, 4'd8},
        '{4'h9, OP_TOK, 8'h00, 8'h13, 4'h0, 1'b0, 4'd3},   // R3 iso ignores stall
        '{4'h9, OP_TXD, 8'h00, 8'h10, NONE, 1'b1, 4'd10},
        '{4'h9, OP_ACK, 8'h00, 8'h10, NONE, 1'b0, 4'd11},
        '{4'h9, OP_TOK, 8'h00, 8'h14, 4'h4, 1'b0, 4'd6},   // R6 ZLP
        '{4'h9, OP_WR,  8'h00, 8'h00, NONE, 1'b0, 4'd4},
        '{4'h8, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},
        '{4'h8, OP_TOK, 8'h00, 8'h03, 4'h1, 1'b0, 4'd11},  // R11 iso kept toggle
        '{4'h8, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd10},
        '{4'h8, OP_ACK, 8'h00, 8'h00, NONE, 1'b0, 4'd11},
        '{4'hA, OP_WR,  8'h01, 8'h02, NONE, 1'b0, 4'd8},   // R8 free slot
        '{4'hA, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},   // R8 full
        '{4'hA, OP_TOK, 8'h00, 8'h03, 4'h0, 1'b0, 4'd11},
        '{4'hA, OP_TXD, 8'h00, 8'h02, NONE, 1'b1, 4'd8},
        '{4'hA, OP_ACK, 8'h00, 8'h02, NONE, 1'b0, 4'd11},
        '{4'hA, OP_TOK, 8'h00, 8'h02, 4'h1, 1'b0, 4'd11},
        '{4'hA, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd7},
        '{4'hA, OP_ACK, 8'h00, 8'h00, NONE, 1'b0, 4'd11},
        '{4'h2, OP_WR,  8'h01, 8'h02, NONE, 1'b0, 4'd8},
        '{4'h2, OP_TOK, 8'h00, 8'h02, 4'h0, 1'b0, 4'd11},
        '{4'h2, OP_TXD, 8'h00, 8'h00, NONE, 1'b0, 4'd10},  // R10 disabled
        '{4'hD, OP_WR,  8'h01, 8'h02, NONE, 1'b0, 4'd9},   // R9 staged
        '{4'hD, OP_TOK, 8'h00, 8'h06, 4'h4, 1'b0, 4'd9},   // R9 ZLP before SOF
        '{4'hD, OP_WR,  8'h00, 8'h02, NONE, 1'b0, 4'd4},
        '{4'hD, OP_SOF, 8'h00, 8'h03, NONE, 1'b0, 4'd9},   // R9 promoted
        '{4'hD, OP_TOK, 8'h00, 8'h03, 4'h0, 1'b0, 4'd9},
        '{4'hD, OP_TXD, 8'h00, 8'h00, NONE, 1'b1, 4'd10},
        '{4'h2, OP_WR,  8'h01, 8'h02, NONE, 1'b0, 4'd8},
        '{4'h2, OP_WR,  8'h01, 8'h03, NONE, 1'b0, 4'd8},
        '{4'h2, OP_WR,  8'h08, 8'h0B, NONE, 1'b0, 4'd5},
        '{4'h2, OP_NOP, 8'h00, 8'h02, NONE, 1'b0, 4'd5},   // R5 one packet only
        '{4'h2, OP_WR,  8'h08, 8'h0A, NONE, 1'b0, 4'd5},
        '{4'h2, OP_NOP, 8'h00, 8'h00, NONE, 1'b0, 4'd5}
    };

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_wdata = 8'h00; tok_in = 1'b0;
        sof = 1'b0; host_ack = 1'b0; tx_done = 1'b0;
    endtask

    task automatic set_cfg(input logic [3:0] c);
        {irq_en, cfg_sof_upd, cfg_dbl, cfg_iso} = c;
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] wd);
        case (op)
            OP_WR:   begin reg_wr = 1'b1; reg_wdata = wd; end
            OP_TOK:  tok_in   = 1'b1;
            OP_SOF:  sof      = 1'b1;
            OP_TXD:  tx_done  = 1'b1;
            OP_ACK:  host_ack = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check_rsp(input logic [3:0] exp, input int req);
        if (exp == NONE)
            check(resp_valid == 1'b0, req, "no response", int'(resp_valid), 0);
        else
            check(resp_valid && resp_kind == exp[2:0], req, "response kind",
                  resp_valid ? int'(resp_kind) : 'hF, int'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        set_cfg(4'h8);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i].cfg);
            apply(VEC[i].op, VEC[i].wd);
            @(negedge clk);
            check(reg_rdata == VEC[i].rd, int'(VEC[i].req), $sformatf("step %0d readback", i),
                  int'(reg_rdata), int'(VEC[i].rd));
            check_rsp(VEC[i].rsp, int'(VEC[i].req));
            check(irq == VEC[i].irq, int'(VEC[i].req), $sformatf("step %0d irq", i),
                  int'(irq), int'(VEC[i].irq));
            idle();
        end

        // R4 collision: underrun set by token while software writes 0 to its bit
        set_cfg(4'h8);
        tok_in = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
        @(negedge clk);
        check(reg_rdata == 8'h04, 4, "hw set wins over sw clear", int'(reg_rdata), 'h04);
        check_rsp(4'h2, 4);
        idle();
        reg_wr = 1'b1; reg_wdata = 8'h00;
        @(negedge clk);
        idle();
        check(reg_rdata == 8'h00, 4, "later clear", int'(reg_rdata), 'h00);

        // R8 collision: commit and transmit completion in one cycle
        set_cfg(4'hA);
        reg_wr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); idle();
        tok_in = 1'b1;
        @(negedge clk); idle();
        check(resp_valid == 1'b1 && resp_kind != 3'd2, 8, "data sent", int'(resp_kind), 0);
        tx_done = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); idle();
        check(reg_rdata == 8'h02, 8, "count unchanged", int'(reg_rdata), 'h02);
        check(irq == 1'b1, 10, "irq on same-cycle completion", int'(irq), 1);
        tok_in = 1'b1;
        @(negedge clk); idle();
        check(resp_valid && (resp_kind == 3'd0 || resp_kind == 3'd1), 8,
              "packet still sendable", int'(resp_kind), 0);

        // R1: reset with state held
        reg_wr = 1'b1; reg_wdata = 8'h11;
        @(negedge clk); idle();
        tok_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        idle();
        check(reg_rdata == 8'h00, 1, "reset readback", int'(reg_rdata), 0);
        check(resp_valid == 1'b0 && irq == 1'b0, 1, "reset outputs", int'({resp_valid, irq}), 0);
        rst = 1'b0;
        tok_in = 1'b1;
        @(negedge clk); idle();
        check_rsp(4'h2, 1);
        @(negedge clk);
        check(resp_valid == 1'b0, 12, "single-cycle response", int'(resp_valid), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule